// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a 32x32 two-colour cursor over a raster stream. Software programs it through a small register window. The window holds 32 mask rows, 32 image rows, a packed X/Y position word and a general-purpose miscellaneous word. The raster side presents one pixel at a time: its x/y coordinate, the underlying colour, and the two cursor colours taken from an external overlay palette. One cycle later the block returns the colour to show, together with a code that tells which source won. The timing generator, the palette storage and the framebuffer fetch all sit outside this block.

The block has no enable bit. Reset parks the cursor far outside the visible area, and software shows the cursor by writing a real position. When a write changes the cursor's appearance or place, the block reports the screen lines that must be repainted. On a move it reports two ranges: the lines the cursor now covers and the lines it has left.

Top module: `cursor_overlay`

## Requirements
- R1: After reset both cursor coordinates are 0xF000, every mask and image row is zero, no pixel is overlaid, no dirty or vacate report is active, and the miscellaneous word is zero.
- R2: A write to byte offset 0x8FC loads the cursor X from write bits [31:16] and the cursor Y from write bits [15:0].
- R3: Mask row i is written at byte offset 0x900 + 4*i and image row i at 0x980 + 4*i, for i from 0 to 31. The row index is the offset above the region base divided by four.
- R4: Within a row word, bit 31 drives the leftmost cursor column. Column c (c = x - X) takes bit 31 - c.
- R5: out_sel and out_color appear one cycle after the pixel input, and out_valid follows pix_valid with the same delay. When the mask bit is 0, out_sel = 0 and the underlying colour passes through. When the mask bit is 1 and the image bit is 1, out_sel = 2 and out_color is the foreground colour. When the mask bit is 1 and the image bit is 0, out_sel = 1 and out_color is the background colour.
- R6: The overlay applies only when Y <= y <= Y+31 and X <= x <= X+31.
- R7: Nothing is overlaid when X >= SCREEN_W, and pixels with x >= SCREEN_W are never overlaid, so the cursor is clipped at the right edge.
- R8: A read of offset 0x818 returns the last value written there ORed with 0x02000000. A read of any other offset returns zero. rdata is updated one cycle after rd_en.
- R9: A write to the position or to any mask or image row raises dirty_vld for one cycle, in the cycle after the write. The reported range is first = Y and last = min(Y+31, SCREEN_H-1), where Y is the position after the write. Nothing is reported when Y >= SCREEN_H.
- R10: A position write also raises vacate_vld for one cycle, in the same cycle as dirty_vld. It reports the same range rule applied to the Y held before the write, and nothing when that Y >= SCREEN_H.
- R11: A write to any other offset, including 0x818, raises neither report and leaves the overlay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| pix_valid | input | 1 | Pixel present |
| pix_x | input | 16 | Pixel column |
| pix_y | input | 16 | Pixel line |
| pix_color | input | COLOR_W | Underlying colour |
| cur_bg_color | input | COLOR_W | Overlay colour for mask 1, image 0 |
| cur_fg_color | input | COLOR_W | Overlay colour for mask 1, image 1 |
| out_valid | output | 1 | Output pixel present |
| out_color | output | COLOR_W | Resulting colour |
| out_sel | output | 2 | 0 pass, 1 background, 2 foreground |
| dirty_vld | output | 1 | Repaint pulse for the covered lines |
| dirty_first | output | 16 | First line to repaint |
| dirty_last | output | 16 | Last line to repaint, inclusive |
| vacate_vld | output | 1 | Repaint pulse for the vacated lines |
| vacate_first | output | 16 | First vacated line |
| vacate_last | output | 16 | Last vacated line, inclusive |

## Verification
The bench builds the block with SCREEN_W = 64 and SCREEN_H = 48. With a screen this small, a 32-pixel cursor crosses the right edge and the bottom edge at easy positions. This brings right-edge clipping, an X exactly at the screen width, and dirty ranges cut off at the last line within reach of a few directed writes. Random positions are drawn in a band slightly larger than the screen, so many random rounds also land partly or fully off screen.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    localparam int DATA_W  = 32;
    localparam int COORD_W = 16;
    localparam int CUR_N   = 32;
    localparam int ROW_W   = $clog2(CUR_N);

    localparam logic [COORD_W-1:0] PARK_POS   = 16'hF000;
    localparam logic [DATA_W-1:0]  MISC_FORCE = 32'h0200_0000;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_BG   = 2'd1,
        SEL_FG   = 2'd2
    } ovl_sel_e;

    typedef struct packed {
        logic               vld;
        logic [COORD_W-1:0] first;
        logic [COORD_W-1:0] last;
    } line_span_t;

    // Lines covered by a cursor whose top edge is at 'top', clamped to the screen.
    function automatic line_span_t span_of(input logic [COORD_W-1:0] top,
                                           input logic [COORD_W:0]   height);
        line_span_t s;
        logic [COORD_W:0] t;
        logic [COORD_W:0] b;
        t = {1'b0, top};
        b = t + (COORD_W+1)'(CUR_N - 1);
        s = '0;
        if (t < height) begin
            s.vld   = 1'b1;
            s.first = top;
            if (b >= height) begin
                b = height - 1'b1;
            end
            s.last = b[COORD_W-1:0];
        end
        return s;
    endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] MISC_OFS = 'h818,
    parameter logic [ADDR_W-1:0] POS_OFS  = 'h8FC,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h900
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic [COORD_W-1:0]          pos_x,
    output logic [COORD_W-1:0]          pos_y,
    output logic [CUR_N-1:0][CUR_N-1:0] mask_rows,
    output logic [CUR_N-1:0][CUR_N-1:0] img_rows,
    output logic                        wr_pos,
    output logic                        wr_row
);

    localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(4 * CUR_N);
    localparam logic [ADDR_W-1:0] IMG_OFS = MASK_OFS + SPAN;

    logic [ADDR_W-1:0] m_off;
    logic [ADDR_W-1:0] i_off;
    logic              in_mask;
    logic              in_img;
    logic [ROW_W-1:0]  m_idx;
    logic [ROW_W-1:0]  i_idx;
    logic [DATA_W-1:0] misc_q;

    always_comb begin
        m_off   = addr - MASK_OFS;
        i_off   = addr - IMG_OFS;
        in_mask = (addr >= MASK_OFS) && (m_off < SPAN);
        in_img  = (addr >= IMG_OFS) && (i_off < SPAN);
        m_idx   = m_off[ROW_W+1:2];
        i_idx   = i_off[ROW_W+1:2];
        wr_pos  = wr_en && (addr == POS_OFS);
        wr_row  = wr_en && (in_mask || in_img);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_x  <= PARK_POS;
            pos_y  <= PARK_POS;
            misc_q <= '0;
        end else if (wr_en) begin
            if (addr == POS_OFS) begin
                pos_x <= wdata[31:16];
                pos_y <= wdata[15:0];
            end
            if (addr == MISC_OFS) begin
                misc_q <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_rows <= '0;
            img_rows  <= '0;
        end else begin
            for (int r = 0; r < CUR_N; r++) begin
                if (wr_en && in_mask && (m_idx == ROW_W'(r))) begin
                    mask_rows[r] <= wdata[CUR_N-1:0];
                end
                if (wr_en && in_img && (i_idx == ROW_W'(r))) begin
                    img_rows[r] <= wdata[CUR_N-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= (addr == MISC_OFS) ? (misc_q | MISC_FORCE) : '0;
        end
    end

    // R1
    park_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pos_x == PARK_POS) && (pos_y == PARK_POS));

    // R2
    pos_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && ($past(addr) == POS_OFS))
        |-> (pos_x == $past(wdata[31:16])) && (pos_y == $past(wdata[15:0])));

    // R8
    rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_en) && ($past(addr) != MISC_OFS)) |-> (rdata == '0));

endmodule

// File: rtl/cursor_dirty.sv
module cursor_dirty
    import cursor_pkg::*;
#(
    parameter int SCREEN_H = 768
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_pos,
    input  logic               wr_row,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] new_y,
    output line_span_t         new_span,
    output line_span_t         old_span
);

    localparam logic [COORD_W:0] H17 = (COORD_W+1)'(SCREEN_H);

    logic [COORD_W-1:0] top_after;

    assign top_after = wr_pos ? new_y : cur_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            new_span <= '0;
            old_span <= '0;
        end else begin
            new_span <= (wr_pos || wr_row) ? span_of(top_after, H17) : '0;
            old_span <= wr_pos ? span_of(cur_y, H17) : '0;
        end
    end

    // R9
    span_order_chk: assert property (@(posedge clk) disable iff (rst)
        new_span.vld |-> (new_span.first <= new_span.last) && ({1'b0, new_span.last} < H17));

    // R9
    span_size_chk: assert property (@(posedge clk) disable iff (rst)
        new_span.vld |-> ((new_span.last - new_span.first) < COORD_W'(CUR_N)));

    // R10
    vacate_cause_chk: assert property (@(posedge clk) disable iff (rst)
        old_span.vld |-> $past(wr_pos));

    // R11
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_pos) && !$past(wr_row)) |-> !new_span.vld);

endmodule

// File: rtl/cursor_pixel.sv
module cursor_pixel
    import cursor_pkg::*;
#(
    parameter int SCREEN_W = 1024,
    parameter int COLOR_W  = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [COORD_W-1:0]          pos_x,
    input  logic [COORD_W-1:0]          pos_y,
    input  logic [CUR_N-1:0][CUR_N-1:0] mask_rows,
    input  logic [CUR_N-1:0][CUR_N-1:0] img_rows,
    input  logic                        pix_valid,
    input  logic [COORD_W-1:0]          pix_x,
    input  logic [COORD_W-1:0]          pix_y,
    input  logic [COLOR_W-1:0]          pix_color,
    input  logic [COLOR_W-1:0]          bg_color,
    input  logic [COLOR_W-1:0]          fg_color,
    output logic                        out_valid,
    output logic [COLOR_W-1:0]          out_color,
    output ovl_sel_e                    out_sel
);

    localparam logic [COORD_W:0] W17 = (COORD_W+1)'(SCREEN_W);
    localparam logic [COORD_W:0] N17 = (COORD_W+1)'(CUR_N);

    logic [COORD_W:0]   dx;
    logic [COORD_W:0]   dy;
    logic               row_hit;
    logic               col_hit;
    logic [ROW_W-1:0]   row;
    logic [ROW_W-1:0]   bitp;
    logic               mbit;
    logic               ibit;
    ovl_sel_e           sel_d;
    logic [COLOR_W-1:0] color_d;

    always_comb begin
        dx      = {1'b0, pix_x} - {1'b0, pos_x};
        dy      = {1'b0, pix_y} - {1'b0, pos_y};
        row_hit = (pix_y >= pos_y) && (dy < N17);
        col_hit = (pix_x >= pos_x) && (dx < N17)
                  && ({1'b0, pix_x} < W17) && ({1'b0, pos_x} < W17);
        row     = dy[ROW_W-1:0];
        bitp    = ROW_W'(CUR_N - 1) - dx[ROW_W-1:0];
        mbit    = mask_rows[row][bitp];
        ibit    = img_rows[row][bitp];
        sel_d   = SEL_PASS;
        if (row_hit && col_hit && mbit) begin
            sel_d = ibit ? SEL_FG : SEL_BG;
        end
        case (sel_d)
            SEL_FG:  color_d = fg_color;
            SEL_BG:  color_d = bg_color;
            default: color_d = pix_color;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sel   <= SEL_PASS;
        end else begin
            out_valid <= pix_valid;
            out_sel   <= sel_d;
        end
    end

    always_ff @(posedge clk) begin
        out_color <= color_d;
    end

    // R5
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sel == SEL_PASS) |-> (out_color == $past(pix_color)));

    // R7
    park_x_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, $past(pos_x)} >= W17) |-> (out_sel == SEL_PASS));

    // R7
    clip_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, $past(pix_x)} >= W17) |-> (out_sel == SEL_PASS));

    // R6
    rows_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(pix_y) < $past(pos_y)) |-> (out_sel == SEL_PASS));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int                SCREEN_W = 1024,
    parameter int                SCREEN_H = 768,
    parameter int                COLOR_W  = 24,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] MISC_OFS = 'h818,
    parameter logic [ADDR_W-1:0] POS_OFS  = 'h8FC,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h900
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               pix_valid,
    input  logic [15:0]        pix_x,
    input  logic [15:0]        pix_y,
    input  logic [COLOR_W-1:0] pix_color,
    input  logic [COLOR_W-1:0] cur_bg_color,
    input  logic [COLOR_W-1:0] cur_fg_color,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color,
    output logic [1:0]         out_sel,
    output logic               dirty_vld,
    output logic [15:0]        dirty_first,
    output logic [15:0]        dirty_last,
    output logic               vacate_vld,
    output logic [15:0]        vacate_first,
    output logic [15:0]        vacate_last
);

    logic [COORD_W-1:0]          pos_x;
    logic [COORD_W-1:0]          pos_y;
    logic [CUR_N-1:0][CUR_N-1:0] mask_rows;
    logic [CUR_N-1:0][CUR_N-1:0] img_rows;
    logic                        wr_pos;
    logic                        wr_row;
    line_span_t                  new_span;
    line_span_t                  old_span;
    ovl_sel_e                    sel_q;

    cursor_regs #(
        .ADDR_W   (ADDR_W),
        .MISC_OFS (MISC_OFS),
        .POS_OFS  (POS_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .rd_en     (reg_rd_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .mask_rows (mask_rows),
        .img_rows  (img_rows),
        .wr_pos    (wr_pos),
        .wr_row    (wr_row)
    );

    cursor_dirty #(
        .SCREEN_H (SCREEN_H)
    ) u_dirty (
        .clk      (clk),
        .rst      (rst),
        .wr_pos   (wr_pos),
        .wr_row   (wr_row),
        .cur_y    (pos_y),
        .new_y    (reg_wdata[15:0]),
        .new_span (new_span),
        .old_span (old_span)
    );

    cursor_pixel #(
        .SCREEN_W (SCREEN_W),
        .COLOR_W  (COLOR_W)
    ) u_pixel (
        .clk       (clk),
        .rst       (rst),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .mask_rows (mask_rows),
        .img_rows  (img_rows),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_color (pix_color),
        .bg_color  (cur_bg_color),
        .fg_color  (cur_fg_color),
        .out_valid (out_valid),
        .out_color (out_color),
        .out_sel   (sel_q)
    );

    assign out_sel      = sel_q;
    assign dirty_vld    = new_span.vld;
    assign dirty_first  = new_span.first;
    assign dirty_last   = new_span.last;
    assign vacate_vld   = old_span.vld;
    assign vacate_first = old_span.first;
    assign vacate_last  = old_span.last;

    // R9
    dirty_cause_chk: assert property (@(posedge clk) disable iff (rst)
        dirty_vld |-> $past(reg_wr_en));

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(pix_valid)));

endmodule

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;

    localparam int SW = 64;
    localparam int SH = 48;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          pix_valid = 1'b0;
    logic [15:0]   pix_x = '0;
    logic [15:0]   pix_y = '0;
    logic [CW-1:0] pix_color = '0;
    logic [CW-1:0] bg_color = 24'h101010;
    logic [CW-1:0] fg_color = 24'hEFEFEF;
    logic          out_valid;
    logic [CW-1:0] out_color;
    logic [1:0]    out_sel;
    logic          dirty_vld;
    logic [15:0]   dirty_first;
    logic [15:0]   dirty_last;
    logic          vacate_vld;
    logic [15:0]   vacate_first;
    logic [15:0]   vacate_last;

    int          errs  = 0;
    int          total = 0;
    bit          done  = 0;
    logic [31:0] m_mask [32];
    logic [31:0] m_img  [32];
    int          m_cx;
    int          m_cy;
    logic [31:0] m_misc;

    always #2.5 clk = ~clk;

    cursor_overlay #(
        .SCREEN_W (SW),
        .SCREEN_H (SH),
        .COLOR_W  (CW),
        .ADDR_W   (12)
    ) i_cursor_overlay (
        .clk          (clk),
        .rst          (rst),
        .reg_wr_en    (wr_en),
        .reg_rd_en    (rd_en),
        .reg_addr     (addr),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata),
        .pix_valid    (pix_valid),
        .pix_x        (pix_x),
        .pix_y        (pix_y),
        .pix_color    (pix_color),
        .cur_bg_color (bg_color),
        .cur_fg_color (fg_color),
        .out_valid    (out_valid),
        .out_color    (out_color),
        .out_sel      (out_sel),
        .dirty_vld    (dirty_vld),
        .dirty_first  (dirty_first),
        .dirty_last   (dirty_last),
        .vacate_vld   (vacate_vld),
        .vacate_first (vacate_first),
        .vacate_last  (vacate_last)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [1:0] exp_sel(input int x, input int y);
        int r;
        int c;
        if (y >= m_cy && y < m_cy + 32 && x >= m_cx && x < m_cx + 32 && x < SW && m_cx < SW) begin
            r = y - m_cy;
            c = x - m_cx;
            if (m_mask[r][31 - c]) begin
                return m_img[r][31 - c] ? 2'd2 : 2'd1;
            end
        end
        return 2'd0;
    endfunction

    task automatic span_check(input bit act_vld, input logic [15:0] act_f, input logic [15:0] act_l,
                              input bit want, input int top, input string tag);
        bit exp_vld;
        exp_vld = want && (top < SH);
        check(act_vld == exp_vld, tag, 64'(act_vld), 64'(exp_vld));
        if (exp_vld && act_vld) begin
            check(act_f == 16'(top), tag, 64'(act_f), 64'(top));
            check(act_l == 16'(min_i(top + 31, SH - 1)), tag, 64'(act_l), 64'(min_i(top + 31, SH - 1)));
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        bit is_pos;
        bit is_row;
        int ny;
        is_pos = (a == 12'h8FC);
        is_row = (a >= 12'h900) && (a < 12'hA00);
        ny     = is_pos ? int'(d[15:0]) : m_cy;
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        span_check(dirty_vld, dirty_first, dirty_last, is_pos || is_row, ny,
                   (is_pos || is_row) ? "R9 dirty" : "R11 dirty");
        span_check(vacate_vld, vacate_first, vacate_last, is_pos, m_cy,
                   is_pos ? "R10 vacate" : "R11 vacate");
        if (is_pos) begin
            m_cx = int'(d[31:16]);
            m_cy = int'(d[15:0]);
        end
        if (a >= 12'h900 && a < 12'h980) m_mask[(a - 12'h900) >> 2] = d;
        if (a >= 12'h980 && a < 12'hA00) m_img[(a - 12'h980) >> 2] = d;
        if (a == 12'h818) m_misc = d;
    endtask

    task automatic reg_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(rdata == exp, tag, 64'(rdata), 64'(exp));
    endtask

    task automatic pix_check(input int x, input int y, input string tag);
        logic [1:0]    es;
        logic [CW-1:0] ec;
        logic [CW-1:0] under;
        under = CW'($urandom);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_x     = 16'(x);
        pix_y     = 16'(y);
        pix_color = under;
        @(negedge clk);
        es = exp_sel(x, y);
        ec = (es == 2'd2) ? fg_color : (es == 2'd1) ? bg_color : under;
        check(out_valid == 1'b1, "R5 valid", 64'(out_valid), 64'd1);
        check(out_sel == es, tag, 64'(out_sel), 64'(es));
        check(out_color == ec, tag, 64'(out_color), 64'(ec));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin
            m_mask[i] = '0;
            m_img[i]  = '0;
        end
        m_cx   = 32'hF000;
        m_cy   = 32'hF000;
        m_misc = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(dirty_vld == 1'b0, "R1 dirty idle", 64'(dirty_vld), 64'd0);
        check(vacate_vld == 1'b0, "R1 vacate idle", 64'(vacate_vld), 64'd0);
        check(out_valid == 1'b0, "R1 out idle", 64'(out_valid), 64'd0);
        reg_read(12'h818, 32'h0200_0000, "R1 misc reset");
        pix_check(0, 0, "R1 parked");
        // R1: rows cleared at reset -- set position, all pixels pass
        reg_write(12'h8FC, {16'd8, 16'd4});
        pix_check(8, 4, "R1 rows clear");
        pix_check(20, 20, "R1 rows clear");

        // R4 bit order, R3 row addressing, R5 selection
        reg_write(12'h900, 32'h8000_0000);
        reg_write(12'h980, 32'h8000_0000);
        reg_write(12'h904, 32'h0000_0001);
        reg_write(12'h984, 32'h0000_0000);
        pix_check(8, 4, "R4 leftmost fg");
        pix_check(9, 4, "R4 next pass");
        pix_check(39, 5, "R4 rightmost bg");
        pix_check(38, 5, "R4 pass");
        pix_check(7, 4, "R6 left of cursor");
        reg_write(12'h97C, 32'hFFFF_FFFF);
        reg_write(12'h9FC, 32'h0000_FFFF);
        pix_check(8, 35, "R3 last row bg");
        pix_check(39, 35, "R3 last row fg");
        pix_check(8, 36, "R6 below cursor");
        pix_check(8, 3, "R6 above cursor");

        // R2 position split
        reg_write(12'h8FC, {16'd20, 16'd10});
        pix_check(20, 10, "R2 moved fg");
        pix_check(8, 4, "R2 old spot pass");
        pix_check(51, 41, "R2 moved last");

        // R7 right edge and parked X
        for (int r = 0; r < 32; r++) begin
            reg_write(12'(12'h900 + 4 * r), 32'hFFFF_FFFF);
            reg_write(12'(12'h980 + 4 * r), $urandom);
        end
        reg_write(12'h8FC, {16'd60, 16'd40});
        pix_check(63, 40, "R7 inside edge");
        pix_check(64, 40, "R7 clipped");
        pix_check(70, 47, "R7 clipped");
        reg_write(12'h8FC, {16'd64, 16'd0});
        pix_check(64, 0, "R7 X at width");
        pix_check(80, 5, "R7 X at width");
        reg_write(12'h8FC, {16'hF000, 16'd0});
        pix_check(0, 0, "R7 X parked");

        // R9 / R10 clamping and off-screen top
        reg_write(12'h8FC, {16'd0, 16'd47});
        reg_write(12'h8FC, {16'd0, 16'd48});
        reg_write(12'h910, 32'h1234_5678);
        reg_write(12'h8FC, {16'd0, 16'd16});

        // R8 misc and other reads
        reg_write(12'h818, 32'h1234_5678);
        reg_read(12'h818, 32'h1234_5678 | 32'h0200_0000, "R8 misc");
        reg_read(12'h900, 32'h0, "R8 mask read zero");
        reg_read(12'h8FC, 32'h0, "R8 pos read zero");

        // R11 unrelated write changes nothing
        reg_write(12'h100, 32'hFFFF_FFFF);
        reg_write(12'h8F8, 32'h0000_0000);
        reg_read(12'h818, 32'h1234_5678 | 32'h0200_0000, "R11 misc kept");
        pix_check(0, 16, "R11 overlay kept");
        pix_check(31, 47, "R11 overlay kept");

        // Random rounds
        for (int rnd = 0; rnd < 40; rnd++) begin
            reg_write(12'h8FC, {16'($urandom_range(0, SW + 4)), 16'($urandom_range(0, SH + 4))});
            for (int k = 0; k < 4; k++) begin
                reg_write(12'(12'h900 + 4 * $urandom_range(0, 31)), $urandom);
                reg_write(12'(12'h980 + 4 * $urandom_range(0, 31)), $urandom);
            end
            for (int k = 0; k < 40; k++) begin
                pix_check(m_cx + $urandom_range(0, 39) - 4 < 0 ? 0 : m_cx + $urandom_range(0, 39) - 4,
                          m_cy + $urandom_range(0, 39) - 4 < 0 ? 0 : m_cy + $urandom_range(0, 39) - 4,
                          "R6 random");
            end
        end

        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R5 valid drop", 64'(out_valid), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

endmodule